// File: doc/BRIEF.md
# Fine-Scroll Display Address Generator

This block produces the screen-memory read addresses for a bitmap display whose memory is laid out in character cells: each character row is a run of 8-byte cells, one byte per scanline of the cell, so consecutive scanlines within a row sit one byte apart and consecutive columns sit eight bytes apart. Software programs a start address through a two-byte register pair. In enhanced mode the start resolves to 2 bytes, which shifts the picture by whole scanlines and splits the top and bottom character rows. In compatibility mode the start resolves only to 64 bytes. A new start value takes effect from the next frame strobe.

On each active line strobe the generator emits one fetch strobe every `FETCH_GAP` clocks, `COLS` times, with the address of that column's byte for the current scanline. It tracks the scanline offset inside the character row, so it knows where the first partial row ends and how many lines the last partial row holds. When wrapping is needed, addresses past the top of the address space fold back to the screen base. Optional region blanking suppresses fetches for the bottom `BLANK_LINES` of the active area and raises the per-line blank flag instead, so that a split character row does not show at both edges of the picture.

Control is a four-state machine. `ST_OFF` covers reset, the frame strobe and the lines past the active area. `ST_FETCH` issues the column fetches of a line. `ST_HOLD` waits out the rest of a fetched line. `ST_BLANK` covers a blanked active line. The transitions are as follows:
- A frame strobe leads from any state to `ST_OFF`.
- A line strobe leads to `ST_FETCH`, `ST_BLANK` or `ST_OFF`, depending on the class of the line it starts.
- After the last column beat, `ST_FETCH` moves to `ST_HOLD`.

Any other cycle keeps the current state.

Top module: `fine_scroll_addr_gen`

## Requirements
- R1: After reset, and until the first frame strobe, `fetch_strobe` is 0 and `line_blank` is 1, even when line strobes arrive.
- R2: The register word is {high byte, low byte}. A write with `wr_hi`=1 sets the high byte and a write with `wr_hi`=0 sets the low byte. In enhanced mode (`enh_mode`=1) the start address is word bits [14:1] with bit 0 forced to 0. Word bits 15 and 0 have no effect.
- R3: In compatibility mode (`enh_mode`=0) the start address is word bits [14:6] with bits [5:0] forced to 0.
- R4: The register pair, `enh_mode` and `blank_en` are sampled only on a frame strobe. Changes made during a frame leave that frame's fetches and blank flags unchanged.
- R5: Counting the line strobe edge as cycle 0, a fetched line shows `fetch_strobe`=1 in the cycles starting at edges 0, G, 2G … (COLS-1)·G, where G = `FETCH_GAP`. The strobe is 0 in every other cycle.
- R6: With start S, sub = S[2:0] and row base S−sub, active line n reads row (sub+n)/8 at scanline (sub+n) mod 8. Column j reads row base + row·COLS·8 + j·8 + scanline. The first partial row therefore holds 8−sub lines and the last holds sub lines.
- R7: An address that reaches 2^ADDR_W continues at `SCREEN_BASE`. Every fetched address lies in [`SCREEN_BASE`, 2^ADDR_W) when the start does.
- R8: With `blank_en`=1 sampled, the last `BLANK_LINES` of the `ACTIVE_LINES` active lines issue no fetch and hold `line_blank`=1. All other active lines hold `line_blank`=0.
- R9: Line strobes after the `ACTIVE_LINES`-th one in a frame issue no fetch and hold `line_blank`=1. The flag changes only at a line or frame strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| wr_data | input | 8 | Register write data |
| enh_mode | input | 1 | 1 selects 2-byte granularity, 0 selects 64-byte granularity |
| blank_en | input | 1 | Enables bottom-region blanking |
| frame_sync | input | 1 | One-cycle frame start strobe (vertical sync) |
| line_sync | input | 1 | One-cycle line start strobe |
| rd_addr | output | ADDR_W | Screen memory read address |
| fetch_strobe | output | 1 | Read request for `rd_addr` in this cycle |
| line_blank | output | 1 | Current line carries no pixel data |

## Verification
Fetch strobes and addresses of a line are due in the cycles that begin at the line strobe edge and at each following multiple of `FETCH_GAP`. `line_blank` is due in the cycle right after a line or frame strobe edge. A start write becomes visible only on the lines after the next frame strobe. The bench drives every strobe for one cycle from a falling edge, then samples all three outputs at each falling edge of the line period. It compares them with addresses computed arithmetically from the start value, the line number and the column. It sweeps every even sub-row offset with and without blanking, across the wrap point, in both modes, and with writes made during a frame.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    // Controller states of the fetch sequencer
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_FETCH = 2'd1,
        ST_HOLD  = 2'd2,
        ST_BLANK = 2'd3
    } fsa_state_e;

    // Classification of the line a line strobe is about to start
    typedef enum logic [1:0] {
        LK_OFF   = 2'd0,
        LK_FETCH = 2'd1,
        LK_BLANK = 2'd2
    } fsa_kind_e;

endpackage

// File: rtl/fsa_start_regs.sv
module fsa_start_regs #(
    parameter int ADDR_W     = 15,
    parameter int COARSE_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    input  logic              enh_mode,
    output logic [ADDR_W-1:0] next_start
);

    // Only word bits [ADDR_W-1:1] can ever reach the address.
    logic [ADDR_W-1:1] pend_q;
    logic              unused_bit0;

    assign unused_bit0 = wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr_en) begin
            if (wr_hi) begin
                pend_q[ADDR_W-1:8] <= wr_data[ADDR_W-9:0];
            end else begin
                pend_q[7:1] <= wr_data[7:1];
            end
        end
    end

    // Granularity chosen by the mode input
    always_comb begin
        next_start = '0;
        if (enh_mode) begin
            next_start[ADDR_W-1:1] = pend_q;
        end else begin
            next_start[ADDR_W-1:COARSE_LSB] = pend_q[ADDR_W-1:COARSE_LSB];
        end
    end

endmodule

// File: rtl/fsa_row_tracker.sv
module fsa_row_tracker
    import fsa_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int SCREEN_BASE  = 'h3000,
    parameter int COLS         = 80,
    parameter int ACTIVE_LINES = 256,
    parameter int BLANK_LINES  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic              line_go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              blank_req,
    output logic [ADDR_W-1:0] line_addr,
    output fsa_kind_e         line_kind
);

    localparam int                LW       = $clog2(ACTIVE_LINES + 1);
    localparam logic [LW-1:0]     ACT_V    = LW'(ACTIVE_LINES);
    localparam logic [LW-1:0]     BLK_V    = LW'(ACTIVE_LINES - BLANK_LINES);
    localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(COLS * 8 - 7);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(SCREEN_BASE);

    logic [ADDR_W-1:0] ls_q;      // column-0 address of the next line
    logic [2:0]        sub_q;     // scanline inside the character row
    logic [2:0]        sub0_q;    // scanline the frame started on
    logic [LW-1:0]     idx_q;     // active lines started in this frame
    logic              blank_q;   // blanking sampled at the frame strobe

    logic              row_carry;
    logic [ADDR_W-1:0] row_sum;
    logic [ADDR_W-1:0] row_next;
    logic [ADDR_W-1:0] ls_next;

    always_comb begin
        {row_carry, row_sum} = {1'b0, ls_q} + {1'b0, ROW_STEP};
        row_next = row_carry ? (row_sum + BASE_A) : row_sum;
        ls_next  = (sub_q == 3'd7) ? row_next : (ls_q + ADDR_W'(1));
    end

    always_comb begin
        if (idx_q >= ACT_V) begin
            line_kind = LK_OFF;
        end else if (blank_q && (idx_q >= BLK_V)) begin
            line_kind = LK_BLANK;
        end else begin
            line_kind = LK_FETCH;
        end
    end

    assign line_addr = ls_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_q    <= BASE_A;
            sub_q   <= '0;
            sub0_q  <= '0;
            idx_q   <= ACT_V;
            blank_q <= 1'b0;
        end else if (frame_go) begin
            ls_q    <= start_addr;
            sub_q   <= start_addr[2:0];
            sub0_q  <= start_addr[2:0];
            idx_q   <= '0;
            blank_q <= blank_req;
        end else if (line_go && (idx_q < ACT_V)) begin
            ls_q  <= ls_next;
            sub_q <= sub_q + 3'd1;
            idx_q <= idx_q + LW'(1);
        end
    end

    // R6: the final active line closes a last partial row of sub0 lines
    last_row_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_go && !frame_go && (idx_q == ACT_V - LW'(1))) |-> (sub_q == sub0_q - 3'd1));

    // R4: the line origin moves only on a strobe
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_go && !line_go) |=> $stable(ls_q));

endmodule

// File: rtl/fsa_fetch_fsm.sv
module fsa_fetch_fsm
    import fsa_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int SCREEN_BASE = 'h3000,
    parameter int COLS        = 80,
    parameter int FETCH_GAP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    input  logic              line_go,
    input  fsa_kind_e         line_kind,
    input  logic [ADDR_W-1:0] line_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              fetch_strobe,
    output logic              line_blank
);

    localparam int                CW       = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int                GW       = (FETCH_GAP > 1) ? $clog2(FETCH_GAP) : 1;
    localparam logic [CW-1:0]     COL_LAST = CW'(COLS - 1);
    localparam logic [GW-1:0]     GAP_LAST = GW'(FETCH_GAP - 1);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(SCREEN_BASE);
    localparam logic [ADDR_W-1:0] CELL     = ADDR_W'(8);

    fsa_state_e        st_q, st_d;
    logic [CW-1:0]     col_q;
    logic [GW-1:0]     gap_q;
    logic [ADDR_W-1:0] cur_q;
    logic              last_beat;
    logic              cell_carry;
    logic [ADDR_W-1:0] cell_sum;
    logic [ADDR_W-1:0] cur_next;

    assign last_beat = (col_q == COL_LAST) && (gap_q == GAP_LAST);

    always_comb begin
        {cell_carry, cell_sum} = {1'b0, cur_q} + {1'b0, CELL};
        cur_next = cell_carry ? (cell_sum + BASE_A) : cell_sum;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (frame_go) begin
            st_d = ST_OFF;
        end else if (line_go) begin
            unique case (line_kind)
                LK_FETCH: st_d = ST_FETCH;
                LK_BLANK: st_d = ST_BLANK;
                default:  st_d = ST_OFF;
            endcase
        end else begin
            unique case (st_q)
                ST_FETCH: if (last_beat) st_d = ST_HOLD;
                ST_HOLD:  st_d = ST_HOLD;
                ST_BLANK: st_d = ST_BLANK;
                ST_OFF:   st_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Column walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            gap_q <= '0;
            cur_q <= BASE_A;
        end else if (frame_go) begin
            col_q <= '0;
            gap_q <= '0;
        end else if (line_go) begin
            col_q <= '0;
            gap_q <= '0;
            cur_q <= line_addr;
        end else if (st_q == ST_FETCH) begin
            if (gap_q == GAP_LAST) begin
                gap_q <= '0;
                col_q <= col_q + CW'(1);
                cur_q <= cur_next;
            end else begin
                gap_q <= gap_q + GW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        rd_addr = cur_q;
        unique case (st_q)
            ST_FETCH: begin
                fetch_strobe = (gap_q == '0);
                line_blank   = 1'b0;
            end
            ST_HOLD: begin
                fetch_strobe = 1'b0;
                line_blank   = 1'b0;
            end
            ST_BLANK, ST_OFF: begin
                fetch_strobe = 1'b0;
                line_blank   = 1'b1;
            end
        endcase
    end

    // R7
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_strobe |-> (rd_addr >= BASE_A));

    // R9
    blank_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_blank) |-> $past(line_go || frame_go));

    generate
        if (FETCH_GAP > 1) begin : g_spacing
            // R5
            fetch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fetch_strobe && !line_go && !frame_go) |=> !fetch_strobe);
        end
    endgenerate

endmodule

// File: rtl/fine_scroll_addr_gen.sv
module fine_scroll_addr_gen
    import fsa_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int COARSE_LSB   = 6,
    parameter int SCREEN_BASE  = 'h3000,
    parameter int COLS         = 80,
    parameter int FETCH_GAP    = 8,
    parameter int ACTIVE_LINES = 256,
    parameter int BLANK_LINES  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    input  logic              enh_mode,
    input  logic              blank_en,
    input  logic              frame_sync,
    input  logic              line_sync,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              fetch_strobe,
    output logic              line_blank
);

    logic [ADDR_W-1:0] next_start;
    logic [ADDR_W-1:0] line_addr;
    fsa_kind_e         line_kind;

    fsa_start_regs #(
        .ADDR_W     (ADDR_W),
        .COARSE_LSB (COARSE_LSB)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .enh_mode   (enh_mode),
        .next_start (next_start)
    );

    fsa_row_tracker #(
        .ADDR_W       (ADDR_W),
        .SCREEN_BASE  (SCREEN_BASE),
        .COLS         (COLS),
        .ACTIVE_LINES (ACTIVE_LINES),
        .BLANK_LINES  (BLANK_LINES)
    ) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_go   (frame_sync),
        .line_go    (line_sync),
        .start_addr (next_start),
        .blank_req  (blank_en),
        .line_addr  (line_addr),
        .line_kind  (line_kind)
    );

    fsa_fetch_fsm #(
        .ADDR_W      (ADDR_W),
        .SCREEN_BASE (SCREEN_BASE),
        .COLS        (COLS),
        .FETCH_GAP   (FETCH_GAP)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_go     (frame_sync),
        .line_go      (line_sync),
        .line_kind    (line_kind),
        .line_addr    (line_addr),
        .rd_addr      (rd_addr),
        .fetch_strobe (fetch_strobe),
        .line_blank   (line_blank)
    );

endmodule

// File: tb/sim_fine_scroll_addr_gen.sv
module sim_fine_scroll_addr_gen;

    localparam int CLK_PERIOD  = 10;
    localparam int ADDR_W      = 15;
    localparam int BASE        = 'h7F00;
    localparam int SPAN        = (1 << ADDR_W) - BASE;
    localparam int COLS        = 4;
    localparam int GAP         = 2;
    localparam int ACTIVE      = 24;
    localparam int BLANKN      = 6;
    localparam int LINE_PERIOD = 12;
    localparam int FRAME_LINES = 28;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_hi = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              enh_mode = 1'b1;
    logic              blank_en = 1'b0;
    logic              frame_sync = 1'b0;
    logic              line_sync = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic              fetch_strobe;
    logic              line_blank;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fine_scroll_addr_gen #(
        .ADDR_W       (ADDR_W),
        .COARSE_LSB   (6),
        .SCREEN_BASE  (BASE),
        .COLS         (COLS),
        .FETCH_GAP    (GAP),
        .ACTIVE_LINES (ACTIVE),
        .BLANK_LINES  (BLANKN)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_hi        (wr_hi),
        .wr_data      (wr_data),
        .enh_mode     (enh_mode),
        .blank_en     (blank_en),
        .frame_sync   (frame_sync),
        .line_sync    (line_sync),
        .rd_addr      (rd_addr),
        .fetch_strobe (fetch_strobe),
        .line_blank   (line_blank)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Address of column j on active line n for start s (R6, R7)
    function automatic int exp_addr(input int s, input int n, input int j);
        int sub0, rb, row, sl, off;
        sub0 = s % 8;
        rb   = s - sub0;
        row  = (sub0 + n) / 8;
        sl   = (sub0 + n) % 8;
        off  = (rb - BASE) + row * COLS * 8 + j * 8 + sl;
        return BASE + (off % SPAN);
    endfunction

    task automatic write_start(input int w);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = 1'b0; wr_data = w[7:0];
        @(negedge clk);
        wr_hi = 1'b1; wr_data = w[15:8];
        @(negedge clk);
        wr_en = 1'b0; wr_hi = 1'b0;
    endtask

    // One frame: frame strobe, then FRAME_LINES lines sampled every cycle
    task automatic run_frame(input int s_exp, input bit blank_exp,
                             input bit mid_write, input int mid_val);
        int visible;
        visible = ACTIVE - (blank_exp ? BLANKN : 0);
        @(negedge clk);
        frame_sync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frame_sync = 1'b0;
        chk(line_blank == 1'b1, "R9 blank after frame strobe", int'(line_blank), 1);
        chk(fetch_strobe == 1'b0, "R9 no fetch after frame strobe", int'(fetch_strobe), 0);
        for (int n = 0; n < FRAME_LINES; n++) begin
            line_sync = 1'b1;
            @(posedge clk);
            @(negedge clk);
            line_sync = 1'b0;
            for (int off = 0; off < LINE_PERIOD; off++) begin
                bit fl, ef;
                if (off > 0) begin
                    @(posedge clk);
                    @(negedge clk);
                end
                if (mid_write && n == 5) begin
                    if (off == 3) begin
                        wr_en = 1'b1; wr_hi = 1'b0; wr_data = mid_val[7:0];
                        enh_mode = ~enh_mode; blank_en = ~blank_en;
                    end else if (off == 4) begin
                        wr_hi = 1'b1; wr_data = mid_val[15:8];
                    end else if (off == 5) begin
                        wr_en = 1'b0; wr_hi = 1'b0;
                    end
                end
                fl = (n < visible);
                ef = fl && (off < COLS * GAP) && (off % GAP == 0);
                chk(fetch_strobe == ef, "R5 R8 R4 fetch cadence", int'(fetch_strobe), int'(ef));
                if (ef && fetch_strobe) begin
                    int ea;
                    ea = exp_addr(s_exp, n, off / GAP);
                    chk(int'(rd_addr) == ea, "R6 R7 R2 R3 R4 address", int'(rd_addr), ea);
                end
                if (n >= ACTIVE) begin
                    chk(line_blank == 1'b1, "R9 blank past active", int'(line_blank), 1);
                end else begin
                    chk(line_blank == !fl, "R8 region blank flag", int'(line_blank), int'(!fl));
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, then line strobes without a frame strobe
        chk(line_blank == 1'b1, "R1 reset blank", int'(line_blank), 1);
        chk(fetch_strobe == 1'b0, "R1 reset fetch", int'(fetch_strobe), 0);
        for (int i = 0; i < 3; i++) begin
            line_sync = 1'b1;
            @(posedge clk);
            @(negedge clk);
            line_sync = 1'b0;
            for (int c = 0; c < 6; c++) begin
                chk(fetch_strobe == 1'b0, "R1 no fetch before frame", int'(fetch_strobe), 0);
                chk(line_blank == 1'b1, "R1 blank before frame", int'(line_blank), 1);
                @(negedge clk);
            end
        end

        // R6 R7 R8: every even sub-row offset, with and without blanking, across the wrap
        for (int k = 0; k < 8; k++) begin
            int s;
            s = 'h7FD0 + 2 * (k % 4);
            enh_mode = 1'b1;
            blank_en = (k >= 4);
            write_start(s);
            run_frame(s, (k >= 4), 1'b0, 0);
        end

        // R2: word bits 15 and 0 ignored in enhanced mode
        enh_mode = 1'b1; blank_en = 1'b0;
        write_start('hFF33);
        run_frame('h7F32, 1'b0, 1'b0, 0);

        // R3 R4: coarse mode, with a write and input changes during the frame
        enh_mode = 1'b0; blank_en = 1'b0;
        write_start('h7FD6);
        run_frame('h7FC0, 1'b0, 1'b1, 'h7F24);

        // R4: the mid-frame write applies from the next frame strobe
        enh_mode = 1'b1; blank_en = 1'b0;
        run_frame('h7F24, 1'b0, 1'b0, 0);

        // R8 R6: blanking with a start on a row boundary
        enh_mode = 1'b1; blank_en = 1'b1;
        write_start('h7F40);
        run_frame('h7F40, 1'b1, 1'b0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule